// File: doc/BRIEF.md
# Quarter-Turn Phase Compensator

This block follows a complex multiplier stage that was fed shared, phase-shifted twiddle coefficients instead of the exact ones. Four complex results arrive in parallel, one per lane. Because of the shared coefficients, each lane's result is off by a fixed multiple of 90 degrees. The block corrects the phase of each lane without using any multiplier. It does this only by swapping the real and imaginary parts and by negating them.

The rotation is fixed by lane index:

| Lane | Factor |
|------|--------|
| 0 | 1 |
| 1 | +j |
| 2 | -1 |
| 3 | -j |

Negating the most negative two's-complement code would overflow, so that case saturates to the most positive code. A bypass input lets the block pass all four lanes through unchanged, for stages that need no correction.

Results are registered with one cycle of latency. A valid flag travels alongside the data with the same delay. Data registers load only on cycles where valid is asserted.

Top module: `quad_phase_fixup`

## Requirements
- R1: With bypass low, lane 0 output equals lane 0 input, one cycle after a valid input.
- R2: With bypass low, lane 1 is multiplied by +j. The output real part is the negated input imaginary part, and the output imaginary part is the input real part.
- R3: With bypass low, lane 2 is negated. Both the real and imaginary parts are negated.
- R4: With bypass low, lane 3 is multiplied by -j. The output real part is the input imaginary part, and the output imaginary part is the negated input real part.
- R5: Negating the most negative code, -2^(W-1), yields the most positive code, 2^(W-1)-1.
- R6: With bypass high on a valid cycle, all four lanes are output unchanged.
- R7: `out_valid` equals `in_valid` from the previous clock edge.
- R8: A clock edge with `rst_n` low clears `out_valid` and all output data to zero.
- R9: On a clock edge with `in_valid` low, the output data holds its previous value.
- Lane k occupies bits [k*W +: W] of each packed data port. W defaults to 16.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Input lanes hold a valid set of data |
| bypass | input | 1 | Pass all lanes through without rotation |
| in_re | input | 4*W | Real parts of the four lanes, lane k at [k*W +: W] |
| in_im | input | 4*W | Imaginary parts of the four lanes |
| out_valid | output | 1 | Output lanes hold a valid set of data |
| out_re | output | 4*W | Compensated real parts |
| out_im | output | 4*W | Compensated imaginary parts |

## Verification
The bench drives the most negative code into every lane that negates an operand. A design that negates by plain two's complement would return that same most negative value instead of the saturated maximum.

It mixes bypass and non-bypass cycles, and applies distinct real and imaginary values in every lane. This catches:
- a swapped lane order;
- rotating by +j where -j belongs;
- forgetting to swap the parts;
- ignoring bypass.

Idle cycles with changing input data expose data registers that load without valid. Back-to-back valid bursts check the one-cycle alignment of the valid flag.

// File: rtl/qpf_pkg.sv
// Package: shared constants and the lane rotation encoding.
// Assumes four lanes; lane index k selects rotation code k.
package qpf_pkg;
    localparam int NUM_LANES = 4;

    // Rotation applied by a lane, numbered to match the lane index.
    typedef enum logic [1:0] {
        ROT_NONE = 2'd0,   // factor 1
        ROT_POSJ = 2'd1,   // factor +j
        ROT_HALF = 2'd2,   // factor -1
        ROT_NEGJ = 2'd3    // factor -j
    } rot_e;
endpackage

// File: rtl/qpf_lane.sv
// Module: combinational quarter-turn rotator for one complex lane.
// Applies the rotation chosen by ROT using swaps and saturating
// negation only. Assumes two's-complement operands of width W.
module qpf_lane
    import qpf_pkg::*;
#(
    parameter int   W   = 16,
    parameter rot_e ROT = ROT_NONE
) (
    input  logic [W-1:0] a_re,
    input  logic [W-1:0] a_im,
    input  logic         skip,
    output logic [W-1:0] y_re,
    output logic [W-1:0] y_im
);
    localparam logic [W-1:0] MOST_NEG = {1'b1, {(W-1){1'b0}}};
    localparam logic [W-1:0] MOST_POS = {1'b0, {(W-1){1'b1}}};

    logic [W-1:0] neg_re;
    logic [W-1:0] neg_im;
    logic [W-1:0] rot_re;
    logic [W-1:0] rot_im;

    // Saturating negation of both parts.
    always_comb begin
        neg_re = (a_re == MOST_NEG) ? MOST_POS : (~a_re + 1'b1);
        neg_im = (a_im == MOST_NEG) ? MOST_POS : (~a_im + 1'b1);
    end

    // Pick the swap/negate pattern for this lane's fixed rotation.
    generate
        if (ROT == ROT_POSJ) begin : g_posj
            assign rot_re = neg_im;
            assign rot_im = a_re;
        end else if (ROT == ROT_HALF) begin : g_half
            assign rot_re = neg_re;
            assign rot_im = neg_im;
        end else if (ROT == ROT_NEGJ) begin : g_negj
            assign rot_re = a_im;
            assign rot_im = neg_re;
        end else begin : g_none
            assign rot_re = a_re;
            assign rot_im = a_im;
        end
    endgenerate

    // Bypass overrides the rotation.
    always_comb begin
        y_re = skip ? a_re : rot_re;
        y_im = skip ? a_im : rot_im;
    end

    // R5
    always_comb begin
        if (!skip && ROT == ROT_HALF && a_re == MOST_NEG)
            sat_neg_chk: assert (y_re == MOST_POS);
    end
endmodule

// File: rtl/quad_phase_fixup.sv
// Module: four-lane phase compensator with one register stage.
// Lane k is rotated by rotation code k (1, +j, -1, -j) unless bypass
// is set. Data loads only when in_valid is high; out_valid follows
// in_valid by one clock. Synchronous active-low reset.
module quad_phase_fixup
    import qpf_pkg::*;
#(
    parameter int W = 16
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   in_valid,
    input  logic                   bypass,
    input  logic [NUM_LANES*W-1:0] in_re,
    input  logic [NUM_LANES*W-1:0] in_im,
    output logic                   out_valid,
    output logic [NUM_LANES*W-1:0] out_re,
    output logic [NUM_LANES*W-1:0] out_im
);
    localparam int BUS_W = NUM_LANES * W;

    logic [BUS_W-1:0] fix_re;
    logic [BUS_W-1:0] fix_im;

    // One rotator per lane; rotation code equals lane index.
    generate
        for (genvar k = 0; k < NUM_LANES; k++) begin : g_lane
            qpf_lane #(
                .W   (W),
                .ROT (rot_e'(k))
            ) u_lane (
                .a_re (in_re[k*W +: W]),
                .a_im (in_im[k*W +: W]),
                .skip (bypass),
                .y_re (fix_re[k*W +: W]),
                .y_im (fix_im[k*W +: W])
            );
        end
    endgenerate

    // Valid flag pipeline stage.
    always_ff @(posedge clk) begin
        if (!rst_n) out_valid <= 1'b0;
        else        out_valid <= in_valid;
    end

    // Output data register, loaded only on valid cycles.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_re <= '0;
            out_im <= '0;
        end else if (in_valid) begin
            out_re <= fix_re;
            out_im <= fix_im;
        end
    end

    // R7
    valid_delay_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);

    // R9
    hold_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> ($stable(out_re) && $stable(out_im)));

    // R6
    bypass_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && bypass) |=> (out_re == $past(in_re) && out_im == $past(in_im)));

    // R1
    lane0_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> (out_re[W-1:0] == $past(in_re[W-1:0])
                      && out_im[W-1:0] == $past(in_im[W-1:0])));

    // R2
    lane1_im_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !bypass) |=> (out_im[2*W-1:W] == $past(in_re[2*W-1:W])));

    // R4
    lane3_re_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !bypass) |=> (out_re[4*W-1:3*W] == $past(in_im[4*W-1:3*W])));
endmodule

// File: tb/quad_phase_fixup_bench.sv
`timescale 1ns/1ps
module quad_phase_fixup_bench;
    localparam int W    = 16;
    localparam int NL   = 4;
    localparam int MAXV = (1 << (W-1)) - 1;
    localparam int MINV = -(1 << (W-1));

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic in_valid = 1'b0;
    logic bypass = 1'b0;
    logic [NL*W-1:0] in_re = '0;
    logic [NL*W-1:0] in_im = '0;
    logic out_valid;
    logic [NL*W-1:0] out_re;
    logic [NL*W-1:0] out_im;

    int errors = 0;
    int checks = 0;
    int exp_re[NL];
    int exp_im[NL];
    bit exp_v = 1'b0;
    string lane_tag[NL];
    string v_tag = "R8";
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    quad_phase_fixup #(.W(W)) u_quad_phase_fixup (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .bypass(bypass),
        .in_re(in_re), .in_im(in_im),
        .out_valid(out_valid), .out_re(out_re), .out_im(out_im)
    );

    function automatic int sneg(int x);
        if (-x > MAXV) return MAXV;
        return -x;
    endfunction

    // Behavioural reference: expected outputs after each rising edge.
    always @(posedge clk) begin
        if (!rst_n) begin
            exp_v = 1'b0;
            v_tag = "R8";
            for (int k = 0; k < NL; k++) begin
                exp_re[k] = 0; exp_im[k] = 0; lane_tag[k] = "R8";
            end
        end else begin
            exp_v = in_valid;
            v_tag = "R7";
            for (int k = 0; k < NL; k++) begin
                int r;
                int i;
                r = $signed(in_re[k*W +: W]);
                i = $signed(in_im[k*W +: W]);
                if (!in_valid) lane_tag[k] = "R9";
                else if (bypass) begin
                    exp_re[k] = r; exp_im[k] = i; lane_tag[k] = "R6";
                end else begin
                    case (k)
                        0: begin exp_re[k] = r; exp_im[k] = i; lane_tag[k] = "R1"; end
                        1: begin exp_re[k] = sneg(i); exp_im[k] = r; lane_tag[k] = "R2";
                                 if (i == MINV) lane_tag[k] = "R5"; end
                        2: begin exp_re[k] = sneg(r); exp_im[k] = sneg(i); lane_tag[k] = "R3";
                                 if (r == MINV || i == MINV) lane_tag[k] = "R5"; end
                        default: begin exp_re[k] = i; exp_im[k] = sneg(r); lane_tag[k] = "R4";
                                 if (r == MINV) lane_tag[k] = "R5"; end
                    endcase
                end
            end
        end
    end

    task automatic compare();
        checks++;
        if (out_valid !== exp_v) begin
            errors++;
            $display("FAIL %s out_valid actual=%0b expected=%0b", v_tag, out_valid, exp_v);
        end
        for (int k = 0; k < NL; k++) begin
            int ar;
            int ai;
            ar = $signed(out_re[k*W +: W]);
            ai = $signed(out_im[k*W +: W]);
            checks++;
            if (ar != exp_re[k] || ai != exp_im[k] || $isunknown(out_re[k*W +: W])) begin
                errors++;
                $display("FAIL %s lane%0d actual=(%0d,%0d) expected=(%0d,%0d)",
                         lane_tag[k], k, ar, ai, exp_re[k], exp_im[k]);
            end
        end
    endtask

    // One cycle: check the previous edge's result, then drive new inputs.
    task automatic cycle(bit v, bit b, logic [NL*W-1:0] re, logic [NL*W-1:0] im);
        @(negedge clk);
        compare();
        in_valid = v; bypass = b; in_re = re; in_im = im;
    endtask

    function automatic logic [NL*W-1:0] rnd_bus();
        logic [NL*W-1:0] v;
        for (int k = 0; k < NL; k++) v[k*W +: W] = W'($urandom);
        return v;
    endfunction

    function automatic logic [NL*W-1:0] fill(int val);
        logic [NL*W-1:0] v;
        for (int k = 0; k < NL; k++) v[k*W +: W] = W'(val);
        return v;
    endfunction

    initial begin
        // R8: reset with busy inputs
        cycle(1'b1, 1'b0, rnd_bus(), rnd_bus());
        cycle(1'b1, 1'b0, rnd_bus(), rnd_bus());
        cycle(1'b1, 1'b1, rnd_bus(), rnd_bus());
        @(negedge clk); compare(); rst_n = 1'b1;
        // R1..R4: distinct values per lane
        cycle(1'b1, 1'b0, {16'sd400, 16'sd300, 16'sd200, 16'sd100},
                          {16'sd44, 16'sd33, 16'sd22, 16'sd11});
        // R5: most negative code in every part
        cycle(1'b1, 1'b0, fill(MINV), fill(MINV));
        cycle(1'b1, 1'b0, fill(MAXV), fill(MINV));
        cycle(1'b1, 1'b0, fill(MINV), fill(MAXV));
        // R6: bypass, including most negative code
        cycle(1'b1, 1'b1, fill(MINV), fill(-5));
        // R9: idle with changing data
        cycle(1'b0, 1'b0, rnd_bus(), rnd_bus());
        cycle(1'b0, 1'b1, rnd_bus(), rnd_bus());
        // mixed random traffic (R1..R7, R9)
        for (int n = 0; n < 300; n++)
            cycle(($urandom % 4) != 0, ($urandom % 3) == 0, rnd_bus(), rnd_bus());
        // R8: mid-run reset
        rst_n = 1'b0;
        cycle(1'b1, 1'b0, rnd_bus(), rnd_bus());
        cycle(1'b0, 1'b0, '0, '0);
        rst_n = 1'b1;
        cycle(1'b1, 1'b0, rnd_bus(), rnd_bus());
        cycle(1'b0, 1'b0, '0, '0);
        @(negedge clk); compare();
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    // Watchdog.
    initial begin
        #100000;
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule